// File: doc/BRIEF.md
# Second-Operand Shifter with Rotated Immediates

This block forms the second ALU operand of a 32-bit integer datapath. From the instruction word it picks one of three operand forms. The first is an 8-bit constant rotated right by an even amount. The second is the Rm register value shifted by a 5-bit amount taken from the instruction. The third is the Rm register value shifted by an amount held in a second register. Alongside the operand it produces the shifter carry-out that a logical ALU operation would store as its carry flag. The register file read and the ALU itself sit outside. The block receives the already-read Rm value and shift-register value, and it receives the current carry flag.

The result is registered once. When `in_valid` is high, the operand, the carry and a decoded form code are captured at the next rising clock edge, and `out_valid` rises for one cycle. When `in_valid` is low, the captured result is held. Shift kinds are encoded in instruction bits 6:5 as 0 = shift left logical, 1 = shift right logical, 2 = shift right arithmetic and 3 = rotate right. In the immediate-amount form, a zero amount field is read differently for each kind.

Top module: `shop_operand_gen`

## Requirements
- R1: Form is chosen from instruction bits. Bits 27:25 = 001 selects the rotated immediate (`form` = 1). Bits 27:25 = 000 with bit 4 = 0 selects the immediate-amount shift (`form` = 2). Bits 27:25 = 000 with bit 7 = 0 and bit 4 = 1 selects the register-amount shift (`form` = 3). A word accepted with `in_valid` high shows up on the outputs one clock later with `out_valid` = 1.
- R2: Rotated immediate. The operand is bits 7:0 zero-extended and rotated right by twice bits 11:8. The carry is bit 31 of that result when bits 11:8 are nonzero, and `carry_in` when they are zero.
- R3: Immediate-amount shift, amount in bits 11:7 and kind in bits 6:5, applied to `rm_val`. A left shift by 0 passes `rm_val` and `carry_in` through. For amounts 1 to 31 the carry is the last bit shifted out.
- R4: Immediate-amount right logical shift with an amount field of 0 acts as a shift by 32. The operand is 0 and the carry is `rm_val[31]`.
- R5: Immediate-amount arithmetic shift with an amount field of 0 acts as a shift by 32. Every operand bit equals `rm_val[31]`, and so does the carry.
- R6: Immediate-amount rotate with an amount field of 0 is a one-place rotate through carry. The operand is {`carry_in`, `rm_val[31:1]`} and the carry is `rm_val[0]`. For amounts 1 to 31 the carry is operand bit 31.
- R7: Register-amount shift uses only `rs_val[7:0]` as the amount, and bits 31:8 are ignored. An amount of 0 passes `rm_val` and `carry_in` through for every kind.
- R8: Register-amount left and right logical shifts by 32 give an operand of 0, with carry `rm_val[0]` for the left shift and `rm_val[31]` for the right shift. Amounts above 32 give operand 0 and carry 0. An arithmetic shift by 32 or more gives sign fill, with carry `rm_val[31]`.
- R9: Register-amount rotate uses the amount modulo 32. A nonzero amount that is a multiple of 32 leaves `rm_val` unchanged, with carry `rm_val[31]`.
- R10: Any other encoding (bits 27:25 not 000 or 001, or 000 with bit 7 = 1 and bit 4 = 1) gives `form` = 0, operand 0 and carry `carry_in`.
- R11: While `in_valid` is low, `out_valid` is 0 one clock later, and `operand`, `carry_out` and `form` keep their values.
- R12: While reset is asserted, `out_valid`, `operand`, `carry_out` and `form` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Capture enable for the current instruction and operands |
| instr | input | 32 | Instruction word |
| rm_val | input | 32 | Value of the register selected by bits 3:0 |
| rs_val | input | 32 | Value of the register selected by bits 11:8 (register-amount form) |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | A new result was captured in the previous cycle |
| operand | output | 32 | Second ALU operand |
| carry_out | output | 1 | Shifter carry-out |
| form | output | 2 | Decoded form: 0 none, 1 immediate, 2 immediate-amount shift, 3 register-amount shift |

## Verification
Two behaviours can meet in the same cycle: the zero-amount reinterpretation of the shift field and the incoming carry reaching the output. A one-place rotate through carry puts `carry_in` into operand bit 31 while the carry-out comes from `rm_val[0]`. A zero register amount or a zero immediate rotate instead forwards `carry_in` straight to `carry_out`. The bench drives these encodings with both carry values, and it also drives nearby amounts (1, 31, 32, 33, multiples of 32, 255). It judges each operand and carry against a model written from the requirements. It also fires a new capture right after a held cycle, to show that the hold and the capture never mix.

// File: rtl/shop_pkg.sv
package shop_pkg;

  typedef enum logic [1:0] {
    FORM_NONE = 2'd0,
    FORM_IMM  = 2'd1,
    FORM_SHI  = 2'd2,
    FORM_SHR  = 2'd3
  } form_e;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } shkind_e;

  localparam int IMM_BITS  = 8;
  localparam int ROT_BITS  = 4;
  localparam int AMT_BITS  = 8;
  localparam int FAMT_BITS = 5;

endpackage

// File: rtl/shop_rotr.sv
module shop_rotr #(
  parameter int DW = 32,
  parameter int SW = $clog2(DW)
) (
  input  logic [DW-1:0] din,
  input  logic [SW-1:0] amt,
  output logic [DW-1:0] dout
);

  logic [DW-1:0] stage [SW+1];

  assign stage[0] = din;

  for (genvar i = 0; i < SW; i++) begin : g_stage
    localparam int STEP = 1 << i;
    assign stage[i+1] = amt[i] ? {stage[i][STEP-1:0], stage[i][DW-1:STEP]} : stage[i];
  end

  assign dout = stage[SW];

endmodule

// File: rtl/shop_decode.sv
module shop_decode
  import shop_pkg::*;
(
  input  logic [31:0]          instr,
  input  logic [AMT_BITS-1:0]  rs_byte,
  output form_e                form,
  output shkind_e              kind,
  output logic [AMT_BITS-1:0]  amount,
  output logic                 field_zero,
  output logic [ROT_BITS-1:0]  rot_field,
  output logic [IMM_BITS-1:0]  imm8
);

  logic [2:0]           cls;
  logic [FAMT_BITS-1:0] famt;
  logic                 unused_hi;

  assign cls       = instr[27:25];
  assign famt      = instr[11:7];
  assign unused_hi = ^{instr[31:28], instr[24:12]};

  always_comb begin
    form = FORM_NONE;
    if (cls == 3'b001) begin
      form = FORM_IMM;
    end else if (cls == 3'b000) begin
      if (!instr[4]) begin
        form = FORM_SHI;
      end else if (!instr[7]) begin
        form = FORM_SHR;
      end
    end
  end

  assign kind       = shkind_e'(instr[6:5]);
  assign amount     = (form == FORM_SHR) ? rs_byte : AMT_BITS'(famt);
  assign field_zero = (form == FORM_SHI) && (famt == '0);
  assign rot_field  = instr[11:8];
  assign imm8       = instr[7:0];

endmodule

// File: rtl/shop_immgen.sv
module shop_immgen
  import shop_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [IMM_BITS-1:0] imm8,
  input  logic [ROT_BITS-1:0] rot_field,
  input  logic                carry_in,
  output logic [DW-1:0]       value,
  output logic                cout
);

  localparam int SW = $clog2(DW);

  logic [DW-1:0] base;
  logic [SW-1:0] rot_amt;

  assign base    = DW'(imm8);
  assign rot_amt = SW'({rot_field, 1'b0});

  shop_rotr #(.DW(DW), .SW(SW)) u_rot (
    .din  (base),
    .amt  (rot_amt),
    .dout (value)
  );

  assign cout = (rot_field == '0) ? carry_in : value[DW-1];

endmodule

// File: rtl/shop_barrel.sv
module shop_barrel
  import shop_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0]       value,
  input  shkind_e             kind,
  input  logic [AMT_BITS-1:0] amount,
  input  logic                field_zero,
  input  logic                carry_in,
  output logic [DW-1:0]       result,
  output logic                cout
);

  localparam int SW = $clog2(DW);
  localparam int AW = (SW + 1 > AMT_BITS + 1) ? SW + 1 : AMT_BITS + 1;

  logic [AW-1:0]        eff;
  logic [AW-1:0]        asr_amt;
  logic                 rrx;
  logic [DW:0]          lsl_w;
  logic [DW:0]          lsr_w;
  logic signed [DW:0]   asr_in;
  logic signed [DW:0]   asr_w;
  logic [DW-1:0]        ror_w;

  assign eff = (field_zero && (kind == SH_LSR || kind == SH_ASR)) ? AW'(DW) : AW'(amount);
  assign rrx = field_zero && (kind == SH_ROR);

  assign asr_amt = (eff > AW'(DW)) ? AW'(DW + 1) : eff;
  assign lsl_w   = {1'b0, value} << eff;
  assign lsr_w   = {value, 1'b0} >> eff;
  assign asr_in  = {value, 1'b0};
  assign asr_w   = asr_in >>> asr_amt;

  shop_rotr #(.DW(DW), .SW(SW)) u_ror (
    .din  (value),
    .amt  (eff[SW-1:0]),
    .dout (ror_w)
  );

  always_comb begin
    result = value;
    cout   = carry_in;
    if (rrx) begin
      result = {carry_in, value[DW-1:1]};
      cout   = value[0];
    end else if (eff != '0) begin
      case (kind)
        SH_LSL: begin
          result = lsl_w[DW-1:0];
          cout   = lsl_w[DW];
        end
        SH_LSR: begin
          result = lsr_w[DW:1];
          cout   = lsr_w[0];
        end
        SH_ASR: begin
          result = asr_w[DW:1];
          cout   = asr_w[0];
        end
        default: begin
          if (eff[SW-1:0] == '0) begin
            result = value;
            cout   = value[DW-1];
          end else begin
            result = ror_w;
            cout   = ror_w[DW-1];
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/shop_operand_gen.sv
module shop_operand_gen
  import shop_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [31:0]   instr,
  input  logic [DW-1:0] rm_val,
  input  logic [DW-1:0] rs_val,
  input  logic          carry_in,
  output logic          out_valid,
  output logic [DW-1:0] operand,
  output logic          carry_out,
  output logic [1:0]    form
);

  logic [1:0] rst_sync;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end

  assign rst_core_n = rst_sync[1];

  form_e                dec_form;
  shkind_e              dec_kind;
  logic [AMT_BITS-1:0]  dec_amount;
  logic                 dec_fzero;
  logic [ROT_BITS-1:0]  dec_rot;
  logic [IMM_BITS-1:0]  dec_imm8;
  logic                 unused_rs;

  assign unused_rs = ^rs_val[DW-1:AMT_BITS];

  shop_decode u_dec (
    .instr      (instr),
    .rs_byte    (rs_val[AMT_BITS-1:0]),
    .form       (dec_form),
    .kind       (dec_kind),
    .amount     (dec_amount),
    .field_zero (dec_fzero),
    .rot_field  (dec_rot),
    .imm8       (dec_imm8)
  );

  logic [DW-1:0] imm_val;
  logic          imm_c;

  shop_immgen #(.DW(DW)) u_imm (
    .imm8      (dec_imm8),
    .rot_field (dec_rot),
    .carry_in  (carry_in),
    .value     (imm_val),
    .cout      (imm_c)
  );

  logic [DW-1:0] sh_val;
  logic          sh_c;

  shop_barrel #(.DW(DW)) u_sh (
    .value      (rm_val),
    .kind       (dec_kind),
    .amount     (dec_amount),
    .field_zero (dec_fzero),
    .carry_in   (carry_in),
    .result     (sh_val),
    .cout       (sh_c)
  );

  logic [DW-1:0] op_d,   op_q;
  logic          c_d,    c_q;
  form_e         form_q;
  logic          valid_q;

  always_comb begin
    case (dec_form)
      FORM_IMM: begin
        op_d = imm_val;
        c_d  = imm_c;
      end
      FORM_SHI, FORM_SHR: begin
        op_d = sh_val;
        c_d  = sh_c;
      end
      default: begin
        op_d = '0;
        c_d  = carry_in;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      valid_q <= 1'b0;
      op_q    <= '0;
      c_q     <= 1'b0;
      form_q  <= FORM_NONE;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        op_q   <= op_d;
        c_q    <= c_d;
        form_q <= dec_form;
      end
    end
  end

  assign out_valid = valid_q;
  assign operand   = op_q;
  assign carry_out = c_q;
  assign form      = form_q;

endmodule

// File: rtl/shop_operand_gen_chk.sv
module shop_operand_gen_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [31:0]   instr,
  input logic [DW-1:0] rm_val,
  input logic          carry_in,
  input logic          out_valid,
  input logic [DW-1:0] operand,
  input logic          carry_out,
  input logic [1:0]    form
);

  logic [1:0] since_rst;
  logic       armed;
  logic       unused_chk;

  assign unused_chk = ^{instr[31:28], instr[24:12]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= 2'd0;
    end else if (since_rst != 2'd3) begin
      since_rst <= since_rst + 2'd1;
    end
  end

  assign armed = (since_rst == 2'd3);

  logic is_imm, is_shi, is_shr;
  assign is_imm = (instr[27:25] == 3'b001);
  assign is_shi = (instr[27:25] == 3'b000) && !instr[4];
  assign is_shr = (instr[27:25] == 3'b000) && !instr[7] && instr[4];

  a_r1_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    armed && in_valid |=> out_valid);

  a_r11_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !in_valid |=> !out_valid && $stable(operand) && $stable(carry_out) && $stable(form));

  a_r2_zero_rotate: assert property (@(posedge clk) disable iff (!rst_n)
    armed && in_valid && is_imm && instr[11:8] == 4'd0 |=>
      operand == DW'($past(instr[7:0])) && carry_out == $past(carry_in));

  a_r4_lsr_zero_field: assert property (@(posedge clk) disable iff (!rst_n)
    armed && in_valid && is_shi && instr[6:5] == 2'd1 && instr[11:7] == 5'd0 |=>
      operand == '0 && carry_out == $past(rm_val[DW-1]));

  a_r5_asr_zero_field: assert property (@(posedge clk) disable iff (!rst_n)
    armed && in_valid && is_shi && instr[6:5] == 2'd2 && instr[11:7] == 5'd0 |=>
      operand == {DW{$past(rm_val[DW-1])}} && carry_out == $past(rm_val[DW-1]));

  a_r6_rotate_extend: assert property (@(posedge clk) disable iff (!rst_n)
    armed && in_valid && is_shi && instr[6:5] == 2'd3 && instr[11:7] == 5'd0 |=>
      operand == {$past(carry_in), $past(rm_val[DW-1:1])} && carry_out == $past(rm_val[0]));

  a_r10_unknown_form: assert property (@(posedge clk) disable iff (!rst_n)
    armed && in_valid && !is_imm && !is_shi && !is_shr |=>
      form == 2'd0 && operand == '0 && carry_out == $past(carry_in));

endmodule

bind shop_operand_gen shop_operand_gen_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .instr     (instr),
  .rm_val    (rm_val),
  .carry_in  (carry_in),
  .out_valid (out_valid),
  .operand   (operand),
  .carry_out (carry_out),
  .form      (form)
);

// File: tb/tb_shop_operand_gen.sv
module tb_shop_operand_gen;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] instr, rm_val, rs_val;
  logic        carry_in;
  logic        out_valid;
  logic [31:0] operand;
  logic        carry_out;
  logic [1:0]  form;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  shop_operand_gen dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .rm_val(rm_val), .rs_val(rs_val), .carry_in(carry_in),
    .out_valid(out_valid), .operand(operand), .carry_out(carry_out), .form(form)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rotr32(input logic [31:0] v, input int n);
    if (n == 0) return v;
    return (v >> n) | (v << (32 - n));
  endfunction

  function automatic void model(input logic [31:0] ins, input logic [31:0] rm,
                                input logic [31:0] rs, input logic cin,
                                output logic [31:0] op, output logic c, output logic [1:0] f);
    int n;
    logic [1:0] t;
    t = ins[6:5];
    op = 32'h0; c = cin; f = 2'd0;
    if (ins[27:25] == 3'b001) begin
      f = 2'd1;
      n = 2 * int'(ins[11:8]);
      op = rotr32({24'h0, ins[7:0]}, n);
      c = (n == 0) ? cin : op[31];
    end else if (ins[27:25] == 3'b000 && !ins[4]) begin
      f = 2'd2;
      n = int'(ins[11:7]);
      case (t)
        2'd0: if (n == 0) begin op = rm; c = cin; end
              else begin op = rm << n; c = rm[32-n]; end
        2'd1: if (n == 0) begin op = 32'h0; c = rm[31]; end
              else begin op = rm >> n; c = rm[n-1]; end
        2'd2: if (n == 0) begin op = {32{rm[31]}}; c = rm[31]; end
              else begin op = $signed(rm) >>> n; c = rm[n-1]; end
        default: if (n == 0) begin op = {cin, rm[31:1]}; c = rm[0]; end
                 else begin op = rotr32(rm, n); c = rm[n-1]; end
      endcase
    end else if (ins[27:25] == 3'b000 && !ins[7] && ins[4]) begin
      f = 2'd3;
      n = int'(rs[7:0]);
      if (n == 0) begin
        op = rm; c = cin;
      end else begin
        case (t)
          2'd0: if (n < 32) begin op = rm << n; c = rm[32-n]; end
                else if (n == 32) begin op = 32'h0; c = rm[0]; end
                else begin op = 32'h0; c = 1'b0; end
          2'd1: if (n < 32) begin op = rm >> n; c = rm[n-1]; end
                else if (n == 32) begin op = 32'h0; c = rm[31]; end
                else begin op = 32'h0; c = 1'b0; end
          2'd2: if (n < 32) begin op = $signed(rm) >>> n; c = rm[n-1]; end
                else begin op = {32{rm[31]}}; c = rm[31]; end
          default: if ((n % 32) == 0) begin op = rm; c = rm[31]; end
                   else begin op = rotr32(rm, n % 32); c = rm[(n % 32) - 1]; end
        endcase
      end
    end
  endfunction

  function automatic logic [31:0] mk_imm(input logic [3:0] rot, input logic [7:0] k);
    return {4'hE, 3'b001, 4'hD, 1'b0, 4'h0, 4'h3, rot, k};
  endfunction

  function automatic logic [31:0] mk_shi(input logic [1:0] t, input logic [4:0] a);
    return {4'hE, 3'b000, 4'hD, 1'b0, 4'h0, 4'h3, a, t, 1'b0, 4'h1};
  endfunction

  function automatic logic [31:0] mk_shr(input logic [1:0] t);
    return {4'hE, 3'b000, 4'hD, 1'b0, 4'h0, 4'h3, 4'h2, 1'b0, t, 1'b1, 4'h1};
  endfunction

  task automatic run(input string req, input logic [31:0] ins, input logic [31:0] rm,
                     input logic [31:0] rs, input logic cin);
    logic [31:0] eo;
    logic        ec;
    logic [1:0]  ef;
    model(ins, rm, rs, cin, eo, ec, ef);
    @(negedge clk);
    in_valid = 1'b1; instr = ins; rm_val = rm; rs_val = rs; carry_in = cin;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " out_valid"}, {31'h0, out_valid}, 32'h1);
    chk({req, " operand"},   operand, eo);
    chk({req, " carry"},     {31'h0, carry_out}, {31'h0, ec});
    chk({req, " form"},      {30'h0, form}, {30'h0, ef});
    instr = $urandom; rm_val = $urandom; rs_val = $urandom; carry_in = ~cin;
    @(negedge clk);
    chk("R11 idle out_valid", {31'h0, out_valid}, 32'h0);
    chk("R11 hold operand",   operand, eo);
    chk("R11 hold carry",     {31'h0, carry_out}, {31'h0, ec});
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] ins, rs;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; instr = '0; rm_val = '0; rs_val = '0; carry_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12 reset out_valid", {31'h0, out_valid}, 32'h0);
    chk("R12 reset operand",   operand, 32'h0);
    chk("R12 reset carry",     {31'h0, carry_out}, 32'h0);
    chk("R12 reset form",      {30'h0, form}, 32'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    run("R2 rot8",       mk_imm(4'd4, 8'hFF), 32'h0, 32'h0, 1'b0);
    run("R2 rot0 c1",    mk_imm(4'd0, 8'h80), 32'h0, 32'h0, 1'b1);
    run("R2 rot30",      mk_imm(4'd15, 8'hC1), 32'h0, 32'h0, 1'b0);
    run("R3 lsl0",       mk_shi(2'd0, 5'd0), 32'h80000001, 32'h0, 1'b1);
    run("R3 lsl4",       mk_shi(2'd0, 5'd4), 32'hF0000001, 32'h0, 1'b0);
    run("R3 lsr31",      mk_shi(2'd1, 5'd31), 32'hC0000000, 32'h0, 1'b0);
    run("R4 lsr0",       mk_shi(2'd1, 5'd0), 32'h80000000, 32'h0, 1'b0);
    run("R5 asr0 neg",   mk_shi(2'd2, 5'd0), 32'h80000000, 32'h0, 1'b0);
    run("R5 asr0 pos",   mk_shi(2'd2, 5'd0), 32'h40000000, 32'h0, 1'b1);
    run("R6 rrx c1",     mk_shi(2'd3, 5'd0), 32'h00000003, 32'h0, 1'b1);
    run("R6 rrx c0",     mk_shi(2'd3, 5'd0), 32'h80000002, 32'h0, 1'b0);
    run("R6 ror1",       mk_shi(2'd3, 5'd1), 32'h00000001, 32'h0, 1'b0);
    run("R7 amt0 hi",    mk_shr(2'd1), 32'h12345678, 32'hFFFFFF00, 1'b1);
    run("R7 amt8",       mk_shr(2'd0), 32'h00FF00FF, 32'hABCDEF08, 1'b0);
    run("R8 lsl32",      mk_shr(2'd0), 32'h00000001, 32'd32, 1'b0);
    run("R8 lsl33",      mk_shr(2'd0), 32'hFFFFFFFF, 32'd33, 1'b1);
    run("R8 lsr32",      mk_shr(2'd1), 32'h80000000, 32'd32, 1'b0);
    run("R8 lsr33",      mk_shr(2'd1), 32'hFFFFFFFF, 32'd33, 1'b1);
    run("R8 asr200",     mk_shr(2'd2), 32'h80000000, 32'd200, 1'b0);
    run("R9 ror36",      mk_shr(2'd3), 32'h0000000F, 32'd36, 1'b0);
    run("R9 ror64",      mk_shr(2'd3), 32'h80000000, 32'd64, 1'b0);
    run("R10 bit7 bit4", 32'hE00000F1, 32'h55555555, 32'h0, 1'b1);
    run("R10 class 101", 32'hEA000010, 32'h55555555, 32'h0, 1'b0);

    for (int i = 0; i < 1500; i++) begin
      int sel;
      sel = $urandom % 4;
      ins = $urandom;
      rs  = $urandom;
      case (sel)
        0: ins[27:25] = 3'b001;
        1: begin ins[27:25] = 3'b000; ins[4] = 1'b0; end
        2: begin
             ins[27:25] = 3'b000; ins[7] = 1'b0; ins[4] = 1'b1;
             case ($urandom % 6)
               0: rs[7:0] = 8'd0;
               1: rs[7:0] = 8'd32;
               2: rs[7:0] = 8'd33;
               3: rs[7:0] = 8'd31 + 8'($urandom % 3);
               default: ;
             endcase
           end
        default: if (ins[27:25] == 3'b001) ins[27:25] = 3'b111;
      endcase
      case (sel)
        0: run("R2 random", ins, $urandom, rs, 1'($urandom));
        1: run("R3 random", ins, $urandom, rs, 1'($urandom));
        2: run("R7 random", ins, $urandom, rs, 1'($urandom));
        default: run("R10 random", ins, $urandom, rs, 1'($urandom));
      endcase
    end

    @(negedge clk);
    in_valid = 1'b1; instr = mk_imm(4'd0, 8'h11); carry_in = 1'b0;
    @(negedge clk);
    chk("R1 back-to-back first", operand, 32'h00000011);
    instr = mk_imm(4'd1, 8'h01);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1 back-to-back second", operand, 32'h40000000);
    chk("R1 back-to-back valid", {31'h0, out_valid}, 32'h1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule